// File: doc/BRIEF.md
# Sample Fetch Stall Timer

This block sits between the audio sample channel and the CPU pipeline. When the channel asks for its next sample byte, the block holds the CPU for a number of cycles and then delivers the byte to the channel's sample buffer. The number of cycles is not fixed. It is picked at the moment of the request from what the bus is doing: whether the CPU is writing and to which address, and whether a sprite copy engine is running and how many transfers it has left.

The stall output freezes the CPU. The same condition, together with sprite activity, also freezes the sampling of interrupt lines. When the countdown ends, the block pulses a load strobe and presents the byte it captured from the read data bus in the last stall cycle. A request that arrives while a stall is running is parked in a one-entry slot. It starts the moment the running stall ends, so the CPU sees one unbroken stall.

Top module: `sample_fetch_stall`

## Requirements
- R1: A request with no CPU write and no sprite copy active gives a stall of 4 cycles.
- R2: A request together with a CPU write to address 0x4014 (the sprite-copy start address) gives a stall of 2 cycles.
- R3: A request together with a CPU write to any address other than 0x4014 gives a stall of 3 cycles.
- R4: A request while the sprite copy is busy and its remaining count equals 2 gives a stall of 1 cycle.
- R5: A request while the sprite copy is busy and its remaining count equals 1 gives a stall of 3 cycles.
- R6: A request while the sprite copy is busy with any other remaining count gives a stall of 2 cycles. A busy sprite copy takes precedence over a CPU write.
- R7: Once a request is accepted at a clock edge, `cpu_stall` is high for exactly the chosen number of cycles after that edge. In the cycle after the last stall cycle, `buf_load` is high for one cycle and `buf_data` holds the `mem_rdata` value sampled at the end of that last stall cycle. `buf_data` changes at no other time.
- R8: `irq_sample_en` is low whenever `cpu_stall` is high or `spr_busy` is high, and is high otherwise.
- R9: A request that arrives while a stall is running is held. Its length is chosen from the bus context at its own request cycle. It starts on the edge where the running stall ends, so `cpu_stall` stays high without a gap.
- R10: Only one request can be held. A further request that arrives while one is already held is dropped.
- R11: Reset clears the countdown and the held request, and drives `cpu_stall`, `buf_load` and `buf_data` to zero. Requests presented during reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Single-cycle request for a sample byte |
| cpu_wr | input | 1 | CPU performs a write this cycle |
| cpu_wr_addr | input | 16 | Address of the CPU write |
| spr_busy | input | 1 | Sprite copy engine is running |
| spr_left | input | 9 | Sprite copy transfers still to do |
| mem_rdata | input | 8 | Read data bus carrying the sample byte |
| cpu_stall | output | 1 | CPU held this cycle |
| irq_sample_en | output | 1 | Interrupt lines may be sampled this cycle |
| buf_load | output | 1 | Sample buffer load strobe |
| buf_data | output | 8 | Byte delivered to the sample buffer |

## Verification
The bench builds the block with its default parameters: the six stall lengths 4/2/3/1/3/2, the trigger address 0x4014, a 9-bit sprite count and the holding slot enabled. With these values every bus context can be reached, including the one-cycle stall. Back-to-back one-cycle stalls make load strobes fall on adjacent cycles. Queued requests chain into unbroken stalls, and a third request lands on a full slot. The read data bus changes every cycle, so a byte captured one cycle early or late shows up as a data mismatch.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

   typedef enum logic [2:0] {
      CTX_QUIET    = 3'd0,
      CTX_TRIG_WR  = 3'd1,
      CTX_PLAIN_WR = 3'd2,
      CTX_SPR_TWO  = 3'd3,
      CTX_SPR_ONE  = 3'd4,
      CTX_SPR_MID  = 3'd5
   } sfs_ctx_e;

   function automatic int unsigned sfs_max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned sfs_max6(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d,
                                            input int unsigned e, input int unsigned f);
      return sfs_max2(sfs_max2(sfs_max2(a, b), sfs_max2(c, d)), sfs_max2(e, f));
   endfunction

endpackage

// File: rtl/sfs_ctx_sel.sv
module sfs_ctx_sel
   import sfs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned SPR_W       = 9,
   parameter int unsigned CNT_W       = 3,
   parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
   parameter int unsigned LEN_QUIET   = 4,
   parameter int unsigned LEN_TRIG    = 2,
   parameter int unsigned LEN_PLAIN   = 3,
   parameter int unsigned LEN_SPR_TWO = 1,
   parameter int unsigned LEN_SPR_ONE = 3,
   parameter int unsigned LEN_SPR_MID = 2
) (
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_wr_addr,
   input  logic              spr_busy,
   input  logic [SPR_W-1:0]  spr_left,
   output logic [CNT_W-1:0]  req_len
);

   localparam logic [SPR_W-1:0] SPR_AT_TWO = SPR_W'(2);
   localparam logic [SPR_W-1:0] SPR_AT_ONE = SPR_W'(1);

   sfs_ctx_e ctx;

   always_comb begin
      if (spr_busy) begin
         if (spr_left == SPR_AT_TWO)      ctx = CTX_SPR_TWO;
         else if (spr_left == SPR_AT_ONE) ctx = CTX_SPR_ONE;
         else                             ctx = CTX_SPR_MID;
      end else if (cpu_wr) begin
         ctx = (cpu_wr_addr == TRIG_ADDR) ? CTX_TRIG_WR : CTX_PLAIN_WR;
      end else begin
         ctx = CTX_QUIET;
      end
   end

   always_comb begin
      unique case (ctx)
         CTX_TRIG_WR:  req_len = CNT_W'(LEN_TRIG);
         CTX_PLAIN_WR: req_len = CNT_W'(LEN_PLAIN);
         CTX_SPR_TWO:  req_len = CNT_W'(LEN_SPR_TWO);
         CTX_SPR_ONE:  req_len = CNT_W'(LEN_SPR_ONE);
         CTX_SPR_MID:  req_len = CNT_W'(LEN_SPR_MID);
         default:      req_len = CNT_W'(LEN_QUIET);
      endcase
   end

endmodule

// File: rtl/sfs_hold_slot.sv
module sfs_hold_slot #(
   parameter int unsigned CNT_W   = 3,
   parameter bit          HOLD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [CNT_W-1:0] push_len,
   input  logic             pop,
   output logic             held,
   output logic [CNT_W-1:0] held_len
);

   generate
      if (HOLD_EN) begin : g_slot
         logic             v_q;
         logic [CNT_W-1:0] len_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q   <= 1'b0;
               len_q <= '0;
            end else if (pop) begin
               v_q   <= push;
               len_q <= push ? push_len : len_q;
            end else if (push && !v_q) begin
               v_q   <= 1'b1;
               len_q <= push_len;
            end
         end

         assign held     = v_q;
         assign held_len = len_q;
      end else begin : g_none
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, push, push_len, pop};
         assign held     = 1'b0;
         assign held_len = '0;
      end
   endgenerate

endmodule

// File: rtl/sfs_countdown.sv
module sfs_countdown #(
   parameter int unsigned CNT_W  = 3,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [CNT_W-1:0]  launch_len,
   input  logic [DATA_W-1:0] rdata,
   output logic              busy,
   output logic              last,
   output logic              load,
   output logic [DATA_W-1:0] data
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   assign busy = (cnt_q != '0);
   assign last = (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (launch) begin
         cnt_q <= launch_len;
      end else if (busy) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load <= 1'b0;
         data <= '0;
      end else begin
         load <= last;
         if (last) data <= rdata;
      end
   end

endmodule

// File: rtl/sample_fetch_stall.sv
module sample_fetch_stall
   import sfs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SPR_W       = 9,
   parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
   parameter int unsigned LEN_QUIET   = 4,
   parameter int unsigned LEN_TRIG    = 2,
   parameter int unsigned LEN_PLAIN   = 3,
   parameter int unsigned LEN_SPR_TWO = 1,
   parameter int unsigned LEN_SPR_ONE = 3,
   parameter int unsigned LEN_SPR_MID = 2,
   parameter bit          HOLD_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_wr_addr,
   input  logic              spr_busy,
   input  logic [SPR_W-1:0]  spr_left,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              cpu_stall,
   output logic              irq_sample_en,
   output logic              buf_load,
   output logic [DATA_W-1:0] buf_data
);

   localparam int unsigned MAX_LEN = sfs_max6(LEN_QUIET, LEN_TRIG, LEN_PLAIN,
                                              LEN_SPR_TWO, LEN_SPR_ONE, LEN_SPR_MID);
   localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

   initial begin
      assert (LEN_QUIET   >= 1) else $error("quiet stall length must be at least 1");
      assert (LEN_TRIG    >= 1) else $error("trigger-write stall length must be at least 1");
      assert (LEN_PLAIN   >= 1) else $error("plain-write stall length must be at least 1");
      assert (LEN_SPR_TWO >= 1) else $error("sprite stall length must be at least 1");
      assert (LEN_SPR_ONE >= 1) else $error("sprite stall length must be at least 1");
      assert (LEN_SPR_MID >= 1) else $error("sprite stall length must be at least 1");
      assert (SPR_W >= 2)       else $error("sprite count must hold the value 2");
   end

   logic [CNT_W-1:0] req_len;
   logic [CNT_W-1:0] held_len;
   logic [CNT_W-1:0] launch_len;
   logic             held, busy, last, launch, push, pop;

   sfs_ctx_sel #(
      .ADDR_W(ADDR_W), .SPR_W(SPR_W), .CNT_W(CNT_W), .TRIG_ADDR(TRIG_ADDR),
      .LEN_QUIET(LEN_QUIET), .LEN_TRIG(LEN_TRIG), .LEN_PLAIN(LEN_PLAIN),
      .LEN_SPR_TWO(LEN_SPR_TWO), .LEN_SPR_ONE(LEN_SPR_ONE), .LEN_SPR_MID(LEN_SPR_MID)
   ) u_sel (
      .cpu_wr(cpu_wr), .cpu_wr_addr(cpu_wr_addr),
      .spr_busy(spr_busy), .spr_left(spr_left), .req_len(req_len)
   );

   // A held request is released exactly when the running countdown ends.
   assign pop        = last & held;
   assign launch     = (fetch_req & ~busy) | (last & (held | fetch_req));
   assign launch_len = pop ? held_len : req_len;
   // Park a request if the counter is running and cannot take it directly.
   assign push       = fetch_req & busy & (~last | held);

   sfs_hold_slot #(.CNT_W(CNT_W), .HOLD_EN(HOLD_EN)) u_hold (
      .clk(clk), .rst_n(rst_n), .push(push), .push_len(req_len),
      .pop(pop), .held(held), .held_len(held_len)
   );

   sfs_countdown #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .launch(launch), .launch_len(launch_len),
      .rdata(mem_rdata), .busy(busy), .last(last),
      .load(buf_load), .data(buf_data)
   );

   assign cpu_stall     = busy;
   assign irq_sample_en = ~busy & ~spr_busy;

endmodule

// File: rtl/sfs_chk.sv
module sfs_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_req,
   input logic              spr_busy,
   input logic              cpu_stall,
   input logic              irq_sample_en,
   input logic              buf_load,
   input logic [DATA_W-1:0] buf_data
);

   AST_REQ_STARTS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !cpu_stall) |=> cpu_stall);                           // R7

   AST_LOAD_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      buf_load |-> $past(cpu_stall));                                     // R7

   AST_DATA_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_load |-> $stable(buf_data));                                   // R7

   AST_IRQ_FROZEN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stall |-> !irq_sample_en);                                      // R8

   AST_IRQ_FROZEN_SPRITE: assert property (@(posedge clk) disable iff (!rst_n)
      spr_busy |-> !irq_sample_en);                                       // R8

   AST_IRQ_OPEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!spr_busy && !cpu_stall) |-> irq_sample_en);                       // R8

endmodule

bind sample_fetch_stall sfs_chk #(.DATA_W(DATA_W)) u_sfs_chk (
   .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .spr_busy(spr_busy),
   .cpu_stall(cpu_stall), .irq_sample_en(irq_sample_en),
   .buf_load(buf_load), .buf_data(buf_data)
);

// File: tb/tb_sample_fetch_stall.sv
module tb_sample_fetch_stall;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [15:0] cpu_wr_addr = '0;
   logic        spr_busy = 1'b0;
   logic [8:0]  spr_left = '0;
   logic [7:0]  mem_rdata = 8'h11;
   logic        cpu_stall, irq_sample_en, buf_load;
   logic [7:0]  buf_data;

   always #10 clk = ~clk;   // 50 MHz

   sample_fetch_stall dut (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .cpu_wr(cpu_wr),
      .cpu_wr_addr(cpu_wr_addr), .spr_busy(spr_busy), .spr_left(spr_left),
      .mem_rdata(mem_rdata), .cpu_stall(cpu_stall), .irq_sample_en(irq_sample_en),
      .buf_load(buf_load), .buf_data(buf_data)
   );

   int    checks = 0;
   int    errors = 0;
   string tag = "R11";
   bit    done = 1'b0;

   // Reference state: remaining stall, held request, last load and byte.
   int    m_left = 0;
   bit    m_held = 0;
   int    m_held_len = 0;
   bit    m_load = 0;
   int    m_byte = 0;

   function automatic int expect_len(bit wr, logic [15:0] a, bit sb, int left);
      if (sb) begin
         if (left == 2) return 1;        // R4
         if (left == 1) return 3;        // R5
         return 2;                       // R6
      end
      if (wr) return (a == 16'h4014) ? 2 : 3;   // R2, R3
      return 4;                                 // R1
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_left = 0; m_held = 0; m_held_len = 0; m_load = 0; m_byte = 0;
      end else begin
         automatic int want = expect_len(cpu_wr, cpu_wr_addr, spr_busy, int'(spr_left));
         m_load = 0;
         if (m_left == 1) begin
            m_load = 1;
            m_byte = int'(mem_rdata);
            if (m_held) begin
               m_left = m_held_len;
               m_held = fetch_req;
               if (fetch_req) m_held_len = want;
            end else begin
               m_left = fetch_req ? want : 0;
            end
         end else if (m_left > 1) begin
            m_left = m_left - 1;
            if (fetch_req && !m_held) begin
               m_held = 1; m_held_len = want;
            end
         end else if (fetch_req) begin
            m_left = want;
         end
      end
   end

   task automatic check(bit ok, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check(cpu_stall === (m_left != 0), "cpu_stall", int'(cpu_stall), int'(m_left != 0));
         check(buf_load === m_load, "buf_load", int'(buf_load), int'(m_load));
         check(buf_data === 8'(m_byte), "buf_data", int'(buf_data), m_byte);
         check(irq_sample_en === (m_left == 0 && !spr_busy), "irq_sample_en",
               int'(irq_sample_en), int'(m_left == 0 && !spr_busy));
      end
   end

   always @(posedge clk) #2 mem_rdata <= mem_rdata + 8'h1D;

   task automatic drive(bit r, bit w, logic [15:0] a, bit sb, int left);
      @(posedge clk);
      #2;
      fetch_req = r; cpu_wr = w; cpu_wr_addr = a; spr_busy = sb; spr_left = 9'(left);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(0, 0, 16'h0000, 0, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tag = "watchdog";
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      tag = "R11";
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      idle(2);

      tag = "R1";  drive(1, 0, 16'h0000, 0, 0);   idle(6);
      tag = "R2";  drive(1, 1, 16'h4014, 0, 0);   idle(5);
      tag = "R3";  drive(1, 1, 16'h2007, 0, 0);   idle(5);
      tag = "R4";  drive(1, 0, 16'h0000, 1, 2);   idle(4);
      tag = "R5";  drive(1, 0, 16'h0000, 1, 1);   idle(5);
      tag = "R6";  drive(1, 0, 16'h0000, 1, 200); idle(4);
      tag = "R6";  drive(1, 1, 16'h2000, 1, 37);  idle(4);

      tag = "R8";
      drive(0, 0, 16'h0000, 1, 50);
      drive(0, 0, 16'h0000, 1, 49);
      idle(2);

      tag = "R9";
      drive(1, 0, 16'h0000, 0, 0);
      idle(1);
      drive(1, 1, 16'h2000, 0, 0);
      idle(10);

      tag = "R10";
      drive(1, 0, 16'h0000, 0, 0);
      drive(1, 1, 16'h4014, 0, 0);
      drive(1, 1, 16'h3000, 0, 0);
      idle(12);

      tag = "R7";
      drive(1, 0, 16'h0000, 1, 2);
      drive(1, 0, 16'h0000, 1, 2);
      drive(1, 0, 16'h0000, 1, 2);
      idle(5);

      tag = "R11";
      drive(1, 0, 16'h0000, 0, 0);
      drive(1, 1, 16'h2000, 0, 0);
      @(posedge clk);
      #2 rst_n = 1'b0;
      drive(1, 0, 16'h0000, 0, 0);
      drive(1, 1, 16'h4014, 0, 0);
      idle(1);
      @(posedge clk);
      #2 rst_n = 1'b1;
      idle(8);

      finish_run();
   end

endmodule